// File: doc/BRIEF.md
# Double-Banked USB IN Endpoint Transmit Buffer

This block buffers outgoing packets for one USB device IN endpoint in two alternating banks. Firmware pushes payload bytes into the bank that is currently open for writing, then arms it with a packet-ready strobe. The open bank then moves to the other bank, so firmware can fill the second payload while the first one waits for, or is being sent in reply to, an IN token.

On the bus side, an IN token starts the stream of the oldest armed bank. If no bank is armed the token is answered with NAK. When the host ACKs a sent packet, that bank is released, its transmit-complete flag is raised, an interrupt is held until firmware clears it, and the DATA0/DATA1 toggle advances. A timeout leaves the bank armed so the whole packet is sent again on the next token.

Both byte paths are valid/ready streams. A write byte is taken on a cycle with `fw_wr_valid` and `fw_wr_ready` both high. `fw_wr_ready` is low while the open bank is still armed. An output byte moves on a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

Top module: `usb_in_pingpong`

## Requirements
- R1: After reset, `fw_pkt_ready` is 00, `fw_txcomp`, `fw_irq`, `fw_overflow`, `tx_valid` and `tx_odd` are 0, and `fw_wr_bank` is 0.
- R2: An accepted write byte is stored in the bank given by `fw_wr_bank`, and the bytes are later sent in the order they were written. `fw_wr_ready` is 0 while bit `fw_wr_bank` of `fw_pkt_ready` is set, and an offered byte is then not stored.
- R3: A `fw_pkt_set` pulse sets bit `fw_wr_bank` of `fw_pkt_ready` (bit 0 is bank 0, bit 1 is bank 1) and toggles `fw_wr_bank`, both visible the cycle after the pulse.
- R4: Armed banks are sent strictly in turn: 0, 1, 0, and so on, starting with bank 0 after reset.
- R5: An `in_token` while no bank is waiting to be sent raises `tx_nak` in the same cycle, and no data beat follows.
- R6: The cycle after an accepted `in_token`, the armed bank streams its bytes with `tx_valid` high and `tx_last` high on the final byte. The outputs hold while `tx_ready` is low.
- R7: An armed bank with zero bytes is sent as one cycle with `tx_last` high and `tx_valid` low, and it is completed like any other packet.
- R8: A `host_ack` after the final beat clears the bank's `fw_pkt_ready` bit, sets `fw_txcomp` and toggles `tx_odd`. `fw_irq` stays high until a `fw_txc_clr` pulse.
- R9: A `host_timeout` after the final beat keeps the bank armed and leaves `tx_odd` and `fw_txcomp` unchanged. The next `in_token` resends the whole packet from its first byte.
- R10: A bank holds up to 64 bytes. A further byte is dropped and sets `fw_overflow`, which is cleared by the next `fw_pkt_set`.
- R11: `fw_txc_clr` and `fw_pkt_set` act independently, so a clear followed one cycle later by a set both take effect. If a release and a clear fall in the same cycle, `fw_txcomp` ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous endpoint reset |
| fw_wr_valid | input | 1 | Firmware write byte valid |
| fw_wr_ready | output | 1 | Open bank can take bytes |
| fw_wr_data | input | 8 | Firmware write byte |
| fw_pkt_set | input | 1 | Arm the open bank |
| fw_txc_clr | input | 1 | Clear transmit-complete |
| fw_wr_bank | output | 1 | Bank currently open for writes |
| fw_pkt_ready | output | 2 | Armed flag per bank |
| fw_txcomp | output | 1 | A bank was sent and acknowledged |
| fw_overflow | output | 1 | A byte was dropped on a full bank |
| fw_irq | output | 1 | Interrupt, high while transmit-complete is set |
| in_token | input | 1 | IN token strobe from the bus side |
| tx_nak | output | 1 | Token answered with NAK |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Bus side takes the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_odd | output | 1 | Data toggle: 0 is DATA0, 1 is DATA1 |
| host_ack | input | 1 | Host acknowledged the packet |
| host_timeout | input | 1 | No handshake came from the host |

## Verification
The send path is tried with a three-byte packet, an empty packet, two banks armed back to back with different lengths, a full 64-byte bank with one extra byte, and a packet held off by `tx_ready` and then lost to a timeout. The back-to-back case tells apart correct bank alternation from sending whichever bank was filled last. The empty and full cases check the two ends of the length range. The timeout case tells a kept bank, rewound to its first byte, from one that is released or resumed partway. Strobe-ordering cases separate independent clear and set handling from one strobe masking the other.

// File: rtl/uip_pkg.sv
package uip_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/uip_bank_store.sv
module uip_bank_store #(
  parameter int DW         = 8,
  parameter int BANK_BYTES = 64,
  localparam int CNTW      = $clog2(BANK_BYTES + 1),
  localparam int PTRW      = $clog2(BANK_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_bank,
  input  logic [DW-1:0]   wr_data,
  input  logic            arm,
  input  logic            rel,
  input  logic            rel_bank,
  input  logic            rd_bank,
  input  logic [PTRW-1:0] rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [CNTW-1:0] rd_len,
  output logic            overflow
);
  logic [DW-1:0]   bank_rd  [2];
  logic [CNTW-1:0] bank_cnt [2];
  logic [1:0]      bank_full;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0]   mem [BANK_BYTES];
    logic [CNTW-1:0] cnt_q;
    logic            we;

    assign bank_full[b] = (cnt_q == CNTW'(BANK_BYTES));
    assign we = wr_en && (wr_bank == 1'(b)) && !bank_full[b];

    always_ff @(posedge clk) begin
      if (we) mem[cnt_q[PTRW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else if (rel && (rel_bank == 1'(b))) cnt_q <= '0;
      else if (we) cnt_q <= cnt_q + CNTW'(1);
    end

    assign bank_rd[b]  = mem[rd_idx];
    assign bank_cnt[b] = cnt_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNTW'(BANK_BYTES)); // R10
  end

  assign rd_data = bank_rd[rd_bank];
  assign rd_len  = bank_cnt[rd_bank];

  always_ff @(posedge clk) begin
    if (!rst_n) overflow <= 1'b0;
    else if (wr_en && bank_full[wr_bank]) overflow <= 1'b1;
    else if (arm) overflow <= 1'b0;
  end

  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_en)); // R10
endmodule

// File: rtl/uip_tx_engine.sv
module uip_tx_engine
  import uip_pkg::*;
#(
  parameter int DW         = 8,
  parameter int BANK_BYTES = 64,
  localparam int CNTW      = $clog2(BANK_BYTES + 1),
  localparam int PTRW      = $clog2(BANK_BYTES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_token,
  input  logic [1:0]      armed,
  input  logic [CNTW-1:0] len,
  input  logic [DW-1:0]   rd_data,
  output logic            rd_bank,
  output logic [PTRW-1:0] rd_idx,
  input  logic            tx_ready,
  output logic            tx_nak,
  output logic            tx_valid,
  output logic [DW-1:0]   tx_data,
  output logic            tx_last,
  output logic            tx_odd,
  input  logic            host_ack,
  input  logic            host_timeout,
  output logic            rel
);
  tx_state_e       state_q;
  logic [CNTW-1:0] rptr_q;
  logic            rsel_q;
  logic            tog_q;
  logic            zlp;
  logic            fire;

  assign zlp      = (len == '0);
  assign tx_valid = (state_q == TX_SEND) && !zlp;
  assign tx_last  = (state_q == TX_SEND) && (zlp || (rptr_q == len - CNTW'(1)));
  assign tx_data  = rd_data;
  assign fire     = tx_valid && tx_ready;
  assign tx_nak   = in_token && (state_q == TX_IDLE) && !armed[rsel_q];
  assign rel      = (state_q == TX_WAIT) && host_ack;
  assign rd_bank  = rsel_q;
  assign rd_idx   = rptr_q[PTRW-1:0];
  assign tx_odd   = tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      rptr_q  <= '0;
      rsel_q  <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (in_token && armed[rsel_q]) begin
            state_q <= TX_SEND;
            rptr_q  <= '0;
          end
        end
        TX_SEND: begin
          if (zlp || (fire && tx_last)) state_q <= TX_WAIT;
          else if (fire) rptr_q <= rptr_q + CNTW'(1);
        end
        TX_WAIT: begin
          if (host_ack) begin
            state_q <= TX_IDLE;
            rsel_q  <= ~rsel_q;
            tog_q   <= ~tog_q;
          end else if (host_timeout) begin
            state_q <= TX_IDLE;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  AST_NAK_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |=> !tx_valid); // R5
  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R6
  AST_TOGGLE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !rel |=> $stable(tx_odd)); // R8
  AST_TIMEOUT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TX_WAIT) && host_timeout && !host_ack) |=> armed[rsel_q]); // R9
endmodule

// File: rtl/usb_in_pingpong.sv
module usb_in_pingpong #(
  parameter int DW         = 8,
  parameter int BANK_BYTES = 64,
  localparam int CNTW      = $clog2(BANK_BYTES + 1),
  localparam int PTRW      = $clog2(BANK_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fw_wr_valid,
  output logic          fw_wr_ready,
  input  logic [DW-1:0] fw_wr_data,
  input  logic          fw_pkt_set,
  input  logic          fw_txc_clr,
  output logic          fw_wr_bank,
  output logic [1:0]    fw_pkt_ready,
  output logic          fw_txcomp,
  output logic          fw_overflow,
  output logic          fw_irq,
  input  logic          in_token,
  output logic          tx_nak,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_data,
  output logic          tx_last,
  output logic          tx_odd,
  input  logic          host_ack,
  input  logic          host_timeout
);
  logic [1:0]      armed_q;
  logic            wsel_q;
  logic            txc_q;
  logic            arm_ok;
  logic            rel;
  logic            rd_bank;
  logic [PTRW-1:0] rd_idx;
  logic [DW-1:0]   rd_data;
  logic [CNTW-1:0] rd_len;

  assign fw_wr_ready  = !armed_q[wsel_q];
  assign arm_ok       = fw_pkt_set && !armed_q[wsel_q];
  assign fw_wr_bank   = wsel_q;
  assign fw_pkt_ready = armed_q;
  assign fw_txcomp    = txc_q;
  assign fw_irq       = txc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 2'b00;
      wsel_q  <= 1'b0;
      txc_q   <= 1'b0;
    end else begin
      for (int b = 0; b < 2; b++) begin
        if (rel && (rd_bank == 1'(b))) armed_q[b] <= 1'b0;
        else if (arm_ok && (wsel_q == 1'(b))) armed_q[b] <= 1'b1;
      end
      if (arm_ok) wsel_q <= ~wsel_q;
      if (rel) txc_q <= 1'b1;
      else if (fw_txc_clr) txc_q <= 1'b0;
    end
  end

  uip_bank_store #(.DW(DW), .BANK_BYTES(BANK_BYTES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (fw_wr_valid && fw_wr_ready),
    .wr_bank  (wsel_q),
    .wr_data  (fw_wr_data),
    .arm      (arm_ok),
    .rel      (rel),
    .rel_bank (rd_bank),
    .rd_bank  (rd_bank),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .rd_len   (rd_len),
    .overflow (fw_overflow)
  );

  uip_tx_engine #(.DW(DW), .BANK_BYTES(BANK_BYTES)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_token     (in_token),
    .armed        (armed_q),
    .len          (rd_len),
    .rd_data      (rd_data),
    .rd_bank      (rd_bank),
    .rd_idx       (rd_idx),
    .tx_ready     (tx_ready),
    .tx_nak       (tx_nak),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .tx_odd       (tx_odd),
    .host_ack     (host_ack),
    .host_timeout (host_timeout),
    .rel          (rel)
  );

  AST_ARM_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (fw_wr_bank != $past(fw_wr_bank))); // R3
  AST_IRQ_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fw_irq) |-> $past(host_ack)); // R8
  AST_REL_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rel |-> fw_pkt_ready[rd_bank]); // R4
endmodule

// File: tb/usb_in_pingpong_tb.sv
module usb_in_pingpong_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fw_wr_valid = 1'b0;
  logic       fw_wr_ready;
  logic [7:0] fw_wr_data = '0;
  logic       fw_pkt_set = 1'b0;
  logic       fw_txc_clr = 1'b0;
  logic       fw_wr_bank;
  logic [1:0] fw_pkt_ready;
  logic       fw_txcomp, fw_overflow, fw_irq;
  logic       in_token = 1'b0;
  logic       tx_nak, tx_valid, tx_last, tx_odd;
  logic       tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic       host_ack = 1'b0;
  logic       host_timeout = 1'b0;

  int checks = 0;
  int errors = 0;
  logic exp_odd = 1'b0;

  always #4 clk = ~clk;

  usb_in_pingpong u_dut (
    .clk(clk), .rst_n(rst_n),
    .fw_wr_valid(fw_wr_valid), .fw_wr_ready(fw_wr_ready), .fw_wr_data(fw_wr_data),
    .fw_pkt_set(fw_pkt_set), .fw_txc_clr(fw_txc_clr), .fw_wr_bank(fw_wr_bank),
    .fw_pkt_ready(fw_pkt_ready), .fw_txcomp(fw_txcomp), .fw_overflow(fw_overflow),
    .fw_irq(fw_irq), .in_token(in_token), .tx_nak(tx_nak), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last), .tx_odd(tx_odd),
    .host_ack(host_ack), .host_timeout(host_timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      fw_wr_valid = 1'b1;
      fw_wr_data  = 8'(base + i);
      @(negedge clk);
    end
    fw_wr_valid = 1'b0;
  endtask

  task automatic arm();
    fw_pkt_set = 1'b1;
    @(negedge clk);
    fw_pkt_set = 1'b0;
  endtask

  task automatic clr_txc();
    fw_txc_clr = 1'b1;
    @(negedge clk);
    fw_txc_clr = 1'b0;
    chk(fw_irq == 1'b0, "R8 irq after clear", int'(fw_irq), 0);
  endtask

  task automatic token(input bit exp_nak, input string req);
    in_token = 1'b1;
    #1;
    chk(tx_nak == exp_nak, req, int'(tx_nak), int'(exp_nak));
    @(negedge clk);
    in_token = 1'b0;
  endtask

  task automatic rx(input int n, input int base, input string req);
    if (n == 0) begin
      chk(tx_valid == 1'b0 && tx_last == 1'b1, req, {tx_valid, tx_last}, 1);
      @(negedge clk);
    end else begin
      for (int i = 0; i < n; i++) begin
        chk(tx_valid == 1'b1 && tx_data == 8'(base + i) && tx_last == (i == n - 1),
            req, {tx_valid, tx_last, tx_data}, {1'b1, (i == n - 1), 8'(base + i)});
        @(negedge clk);
      end
    end
  endtask

  task automatic ack(input bit also_clr);
    host_ack   = 1'b1;
    fw_txc_clr = also_clr;
    @(negedge clk);
    host_ack   = 1'b0;
    fw_txc_clr = 1'b0;
    exp_odd    = ~exp_odd;
    chk(fw_txcomp && fw_irq, "R8 txcomp/irq after ack", {fw_txcomp, fw_irq}, 3);
    chk(tx_odd == exp_odd, "R8 toggle flips on ack", int'(tx_odd), int'(exp_odd));
  endtask

  task automatic t_reset();
    chk(fw_pkt_ready == 2'b00 && !fw_txcomp && !fw_irq && !fw_overflow, "R1 flags",
        {fw_pkt_ready, fw_txcomp, fw_irq, fw_overflow}, 0);
    chk(!tx_valid && !tx_odd && !fw_wr_bank && fw_wr_ready, "R1 bus/bank",
        {tx_valid, tx_odd, fw_wr_bank, fw_wr_ready}, 1);
  endtask

  task automatic t_nak();
    token(1'b1, "R5 nak when nothing armed");
    chk(!tx_valid && !tx_last, "R5 no data after nak", {tx_valid, tx_last}, 0);
  endtask

  task automatic t_basic();
    wr_bytes(3, 8'h20);
    arm();
    chk(fw_pkt_ready == 2'b01 && fw_wr_bank == 1'b1, "R3 arm bank0",
        {fw_pkt_ready, fw_wr_bank}, 3);
    token(1'b0, "R5 no nak when armed");
    rx(3, 8'h20, "R6 three-byte stream");
    ack(1'b0);
    chk(fw_pkt_ready == 2'b00, "R8 bank released", fw_pkt_ready, 0);
    repeat (3) @(negedge clk);
    chk(fw_irq == 1'b1, "R8 irq held", int'(fw_irq), 1);
    clr_txc();
  endtask

  task automatic t_zlp_and_order();
    arm();
    chk(fw_pkt_ready == 2'b10, "R7 empty bank1 armed", fw_pkt_ready, 2);
    token(1'b0, "R7 token accepted");
    rx(0, 0, "R7 zero-length beat");
    ack(1'b0);
    fw_txc_clr = 1'b1;
    @(negedge clk);
    fw_txc_clr = 1'b0;
    fw_pkt_set = 1'b1;
    @(negedge clk);
    fw_pkt_set = 1'b0;
    chk(!fw_txcomp && fw_pkt_ready == 2'b01, "R11 clear then set",
        {fw_txcomp, fw_pkt_ready}, 1);
    token(1'b0, "R7 second empty");
    rx(0, 0, "R7 zero-length beat 2");
    ack(1'b1);
    @(negedge clk);
    chk(fw_txcomp == 1'b1, "R11 release wins over clear", int'(fw_txcomp), 1);
    clr_txc();
  endtask

  task automatic t_pingpong();
    wr_bytes(2, 8'h40);
    arm();
    wr_bytes(3, 8'h60);
    arm();
    chk(fw_pkt_ready == 2'b11 && !fw_wr_ready, "R2 both armed blocks writes",
        {fw_pkt_ready, fw_wr_ready}, 6);
    wr_bytes(1, 8'hEE);
    token(1'b0, "R4 token bank1");
    rx(2, 8'h40, "R4 bank1 sent first");
    ack(1'b0);
    chk(fw_pkt_ready == 2'b01, "R4 bank1 released", fw_pkt_ready, 1);
    clr_txc();
    token(1'b0, "R4 token bank0");
    rx(3, 8'h60, "R2 bank0 data, blocked byte absent");
    ack(1'b0);
    clr_txc();
  endtask

  task automatic t_timeout();
    wr_bytes(4, 8'h80);
    arm();
    tx_ready = 1'b0;
    token(1'b0, "R6 token");
    chk(tx_valid && tx_data == 8'h80, "R6 first beat", {tx_valid, tx_data}, 9'h180);
    repeat (2) @(negedge clk);
    chk(tx_valid && tx_data == 8'h80 && !tx_last, "R6 hold under back-pressure",
        {tx_valid, tx_last, tx_data}, 10'h280);
    tx_ready = 1'b1;
    rx(4, 8'h80, "R6 stream after stall");
    host_timeout = 1'b1;
    @(negedge clk);
    host_timeout = 1'b0;
    chk(fw_pkt_ready == 2'b10 && !fw_txcomp && tx_odd == exp_odd, "R9 kept after timeout",
        {fw_pkt_ready, fw_txcomp, tx_odd}, {2'b10, 1'b0, exp_odd});
    token(1'b0, "R9 retry token");
    rx(4, 8'h80, "R9 full resend");
    ack(1'b0);
    clr_txc();
  endtask

  task automatic t_overflow();
    wr_bytes(65, 8'h10);
    chk(fw_overflow == 1'b1, "R10 overflow set", int'(fw_overflow), 1);
    arm();
    chk(fw_overflow == 1'b0, "R10 overflow cleared by arm", int'(fw_overflow), 0);
    token(1'b0, "R10 token");
    rx(64, 8'h10, "R10 64 bytes kept");
    ack(1'b0);
    clr_txc();
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nak();
    t_basic();
    t_zlp_and_order();
    t_pingpong();
    t_timeout();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule